// File: doc/BRIEF.md
# Keypad Entry with Scrolling Display

This block reads a 4x4 key matrix and turns each deliberate key press into one key event. It drives one row of the matrix at a time and samples the column lines. It accepts a key only once a single key has read steady for a set number of millisecond ticks. While two or more keys are down, it accepts nothing. After a key is accepted, the matrix must read empty for the same interval before the next key can count.

The key events feed an entry controller. A start command tells the controller how many digits to collect. Each digit enters a four-digit display at the right-hand position and pushes the older digits to the left, so a number longer than the display scrolls through it. A digit count of nine, for example, scrolls the first five digits off the left edge. The digits are also kept in a BCD register as wide as the longest entry. The SEND key ends the entry, but only once the requested number of digits is in. The block then pulses done and shows the whole value.

When no entry is active, keys 1 to 5 act as multiple-choice answers A to E and are reported on a separate output.

Top module: `keypad_entry`

## Requirements
- R1: `row_o` drives exactly one row high and moves to the next row on every clock, from bit 0 up to bit 3 and back to bit 0. The bit 0 row is driven out of reset. A high bit c on `col_i` while row r is driven means key index r*4+c is pressed.
- R2: A key is accepted only after the matrix has shown that single key, unchanged, for DEB_TICKS consecutive `tick_i` pulses. A shorter press has no effect.
- R3: After a key is accepted, no other key is accepted until the matrix has read empty for DEB_TICKS consecutive ticks.
- R4: While more than one key is pressed, no key is accepted.
- R5: Key index 0-9 is the digit of the same value, index 10 is CLEAR and index 11 is SEND. Indices 12-15 have no effect on the display, the value or the choice output.
- R6: A `start_i` pulse begins an entry. It takes `len_i` as the digit count (values above MAX_DIGITS are taken as MAX_DIGITS), empties the digit buffer and blanks every display position. Out of reset, all positions are blank and `value_o` is 0.
- R7: Each accepted digit enters `disp_o[3:0]`, the rightmost position, and each older digit moves one position left (4 bits per position). The matching bit of `disp_blank_o` (bit 0 is the rightmost) is cleared. Blank positions are always the leftmost ones.
- R8: Digits accepted after the requested count has been reached are ignored.
- R9: CLEAR during an entry empties the buffer, resets the digit count and blanks the whole display. The entry stays open.
- R10: SEND, once the digit count equals the requested count, raises `done_o` for one clock and loads `value_o` with the entered digits as BCD, the last digit in bits [3:0]. `value_o` changes at no other time, and the entry closes.
- R11: SEND before the requested count is reached is ignored. Digits, CLEAR and SEND while no entry is active change neither the display nor `value_o`.
- R12: While no entry is active, key index 1 to 5 gives a one-clock `choice_valid_o` pulse with `choice_o` = index-1 (0 = A through 4 = E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse every millisecond |
| row_o | output | 4 | Row drive, one-hot, active high |
| col_i | input | 4 | Column sense, high = key closed on driven row |
| start_i | input | 1 | Begin an entry |
| len_i | input | $clog2(MAX_DIGITS+1) | Requested digit count |
| disp_o | output | 4*DISP_DIGITS | Display digits, rightmost in bits [3:0] |
| disp_blank_o | output | DISP_DIGITS | Per-position blank flag, bit 0 rightmost |
| done_o | output | 1 | One-clock entry completion pulse |
| value_o | output | 4*MAX_DIGITS | Completed entry as BCD |
| choice_valid_o | output | 1 | Multiple-choice answer pulse |
| choice_o | output | 3 | Answer 0..4 for A..E |

## Verification
The bench builds the block with DEB_TICKS = 6, MAX_DIGITS = 9 and DISP_DIGITS = 4, and pulses tick_i every 8 clocks. Because the debounce interval is short, presses just under and just over the acceptance window and short release gaps can be driven in a few hundred clocks each. The full nine-digit width lets random entries scroll up to five digits off the display while the complete BCD value is still compared at SEND.

// File: rtl/kpe_pkg.sv
package kpe_pkg;
  localparam int N_ROWS = 4;
  localparam int N_COLS = 4;
  localparam int N_KEYS = N_ROWS * N_COLS;
  localparam int KEY_W  = $clog2(N_KEYS);

  localparam logic [KEY_W-1:0] KEY_CLEAR = KEY_W'(10);
  localparam logic [KEY_W-1:0] KEY_SEND  = KEY_W'(11);

  function automatic logic is_digit(input logic [KEY_W-1:0] k);
    return k <= KEY_W'(9);
  endfunction
endpackage

// File: rtl/kpe_scan.sv
module kpe_scan
  import kpe_pkg::*;
#(
  parameter int DEB_TICKS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [N_ROWS-1:0] row_o,
  input  logic [N_COLS-1:0] col_i,
  output logic              key_vld_o,
  output logic [KEY_W-1:0]  key_code_o
);
  localparam int RW = $clog2(N_ROWS);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] DEB = CW'(DEB_TICKS);

  logic [RW-1:0]     row_idx;
  logic [N_KEYS-1:0] acc_q, frame_n, frame_q, prev_q;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              armed_q;
  logic              same, none, single;
  logic [KEY_W-1:0]  idx;

  always_comb begin
    for (int r = 0; r < N_ROWS; r++) row_o[r] = (row_idx == RW'(r));
  end

  // frame completed with the row sampled this cycle
  always_comb begin
    frame_n = acc_q;
    frame_n[row_idx*N_COLS +: N_COLS] = col_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_idx <= '0;
      acc_q   <= '0;
      frame_q <= '0;
    end else begin
      row_idx <= (row_idx == RW'(N_ROWS - 1)) ? '0 : row_idx + 1'b1;
      acc_q   <= frame_n;
      if (row_idx == RW'(N_ROWS - 1)) frame_q <= frame_n;
    end
  end

  always_comb begin
    same   = (frame_q == prev_q);
    none   = (frame_q == '0);
    single = $onehot(frame_q);
    cnt_n  = same ? ((cnt_q == DEB) ? DEB : cnt_q + 1'b1) : CW'(1);
    idx    = '0;
    for (int i = 0; i < N_KEYS; i++)
      if (frame_q[i]) idx = idx | KEY_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      cnt_q      <= '0;
      armed_q    <= 1'b1;
      key_vld_o  <= 1'b0;
      key_code_o <= '0;
    end else begin
      key_vld_o <= 1'b0;
      if (tick_i) begin
        prev_q <= frame_q;
        cnt_q  <= cnt_n;
        if (none && cnt_n == DEB) armed_q <= 1'b1;
        if (armed_q && single && cnt_n == DEB) begin
          armed_q    <= 1'b0;
          key_vld_o  <= 1'b1;
          key_code_o <= idx;
        end
      end
    end
  end
endmodule

// File: rtl/kpe_entry.sv
module kpe_entry
  import kpe_pkg::*;
#(
  parameter int MAX_DIGITS  = 9,
  parameter int DISP_DIGITS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     key_vld_i,
  input  logic [KEY_W-1:0]         key_code_i,
  input  logic                     start_i,
  input  logic [LW-1:0]            len_i,
  output logic [4*DISP_DIGITS-1:0] disp_o,
  output logic [DISP_DIGITS-1:0]   blank_o,
  output logic                     done_o,
  output logic [4*MAX_DIGITS-1:0]  value_o,
  output logic                     choice_vld_o,
  output logic [2:0]               choice_o
);
  localparam int LW = $clog2(MAX_DIGITS + 1);
  localparam int BW = 4 * MAX_DIGITS;
  localparam int DW = 4 * DISP_DIGITS;
  localparam logic [LW-1:0] MAXL = LW'(MAX_DIGITS);

  logic          active_q;
  logic [LW-1:0] len_q, cnt_q;
  logic [BW-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      len_q        <= '0;
      cnt_q        <= '0;
      buf_q        <= '0;
      disp_o       <= '0;
      blank_o      <= '1;
      done_o       <= 1'b0;
      value_o      <= '0;
      choice_vld_o <= 1'b0;
      choice_o     <= '0;
    end else begin
      done_o       <= 1'b0;
      choice_vld_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        len_q    <= (len_i > MAXL) ? MAXL : len_i;
        cnt_q    <= '0;
        buf_q    <= '0;
        disp_o   <= '0;
        blank_o  <= '1;
      end else if (key_vld_i) begin
        if (active_q) begin
          if (is_digit(key_code_i)) begin
            if (cnt_q < len_q) begin
              buf_q   <= {buf_q[BW-5:0], key_code_i};
              disp_o  <= {disp_o[DW-5:0], key_code_i};
              blank_o <= {blank_o[DISP_DIGITS-2:0], 1'b0};
              cnt_q   <= cnt_q + 1'b1;
            end
          end else if (key_code_i == KEY_CLEAR) begin
            cnt_q   <= '0;
            buf_q   <= '0;
            disp_o  <= '0;
            blank_o <= '1;
          end else if (key_code_i == KEY_SEND && cnt_q == len_q) begin
            done_o   <= 1'b1;
            value_o  <= buf_q;
            active_q <= 1'b0;
          end
        end else if (key_code_i >= KEY_W'(1) && key_code_i <= KEY_W'(5)) begin
          choice_vld_o <= 1'b1;
          choice_o     <= 3'(key_code_i - KEY_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/keypad_entry.sv
module keypad_entry
  import kpe_pkg::*;
#(
  parameter int DEB_TICKS   = 20,
  parameter int MAX_DIGITS  = 9,
  parameter int DISP_DIGITS = 4,
  localparam int LW = $clog2(MAX_DIGITS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  output logic [3:0]               row_o,
  input  logic [3:0]               col_i,
  input  logic                     start_i,
  input  logic [LW-1:0]            len_i,
  output logic [4*DISP_DIGITS-1:0] disp_o,
  output logic [DISP_DIGITS-1:0]   disp_blank_o,
  output logic                     done_o,
  output logic [4*MAX_DIGITS-1:0]  value_o,
  output logic                     choice_valid_o,
  output logic [2:0]               choice_o
);
  logic             key_vld;
  logic [KEY_W-1:0] key_code;

  kpe_scan #(.DEB_TICKS(DEB_TICKS)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .row_o      (row_o),
    .col_i      (col_i),
    .key_vld_o  (key_vld),
    .key_code_o (key_code)
  );

  kpe_entry #(.MAX_DIGITS(MAX_DIGITS), .DISP_DIGITS(DISP_DIGITS)) u_entry (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_vld_i    (key_vld),
    .key_code_i   (key_code),
    .start_i      (start_i),
    .len_i        (len_i),
    .disp_o       (disp_o),
    .blank_o      (disp_blank_o),
    .done_o       (done_o),
    .value_o      (value_o),
    .choice_vld_o (choice_valid_o),
    .choice_o     (choice_o)
  );
endmodule

// File: rtl/keypad_entry_chk.sv
module keypad_entry_chk #(
  parameter int MAX_DIGITS  = 9,
  parameter int DISP_DIGITS = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic [3:0]              row_i,
  input logic                    key_vld_i,
  input logic                    done_i,
  input logic [4*MAX_DIGITS-1:0] value_i,
  input logic [DISP_DIGITS-1:0]  blank_i,
  input logic                    choice_vld_i,
  input logic [2:0]              choice_i
);
  localparam logic [DISP_DIGITS-1:0] LOW_MASK = {1'b0, {(DISP_DIGITS-1){1'b1}}};

  a_r1_row_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(row_i));
  a_r1_row_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> row_i == {$past(row_i[2:0]), $past(row_i[3])});
  a_r2_accept_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_i |-> $past(tick_i));
  a_r7_blank_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((blank_i & ~(blank_i >> 1)) & LOW_MASK) == '0);
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  a_r10_done_from_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(key_vld_i));
  a_r10_value_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(value_i));
  a_r12_choice_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    choice_vld_i |-> (choice_i <= 3'd4 && $past(key_vld_i)));
endmodule

bind keypad_entry keypad_entry_chk #(
  .MAX_DIGITS(MAX_DIGITS), .DISP_DIGITS(DISP_DIGITS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .row_i        (row_o),
  .key_vld_i    (key_vld),
  .done_i       (done_o),
  .value_i      (value_o),
  .blank_i      (disp_blank_o),
  .choice_vld_i (choice_valid_o),
  .choice_i     (choice_o)
);

// File: tb/keypad_entry_bench.sv
`timescale 1ns/1ps
module keypad_entry_bench;
  localparam int DEB  = 6;
  localparam int MAXD = 9;
  localparam int DISP = 4;
  localparam int LW   = $clog2(MAXD + 1);
  localparam int TPER = 8;
  localparam int LONG = DEB + 3;
  localparam int SHRT = DEB - 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [3:0] row, col;
  logic [LW-1:0] len = '0;
  logic [4*DISP-1:0] disp;
  logic [DISP-1:0] blank;
  logic done, chv;
  logic [4*MAXD-1:0] value;
  logic [2:0] ch;
  logic [15:0] keys = '0;
  int tcnt = 0;
  int checks = 0, fails = 0;
  int done_cnt = 0, ch_cnt = 0;
  logic [4*MAXD-1:0] done_val = '0;
  logic [2:0] ch_val = '0;
  int cyc = 0;

  // bench model
  logic m_act = 1'b0;
  int m_len = 0, m_cnt = 0, m_done = 0;
  logic [4*DISP-1:0] m_disp = '0;
  logic [DISP-1:0] m_blank = '1;
  logic [4*MAXD-1:0] m_buf = '0, m_val = '0;

  always #2 clk = ~clk;

  keypad_entry #(.DEB_TICKS(DEB), .MAX_DIGITS(MAXD), .DISP_DIGITS(DISP)) u_keypad_entry (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .row_o(row), .col_i(col),
    .start_i(start), .len_i(len), .disp_o(disp), .disp_blank_o(blank),
    .done_o(done), .value_o(value), .choice_valid_o(chv), .choice_o(ch)
  );

  always_comb begin
    col = '0;
    for (int r = 0; r < 4; r++) if (row[r]) col = col | keys[r*4 +: 4];
  end

  always @(posedge clk) begin
    tcnt <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TPER - 1);
    cyc  <= cyc + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (done) begin done_cnt++; done_val = value; end
    if (chv) begin ch_cnt++; ch_val = ch; end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4*MAXD-1:0] shift_val(input logic [4*MAXD-1:0] v, input int d);
    return {v[4*MAXD-5:0], 4'(d)};
  endfunction

  task automatic model_key(input int k);
    if (m_act) begin
      if (k <= 9) begin
        if (m_cnt < m_len) begin
          m_buf = shift_val(m_buf, k);
          m_disp = {m_disp[4*DISP-5:0], 4'(k)};
          m_blank = {m_blank[DISP-2:0], 1'b0};
          m_cnt++;
        end
      end else if (k == 10) begin
        m_buf = '0; m_disp = '0; m_blank = '1; m_cnt = 0;
      end else if (k == 11 && m_cnt == m_len) begin
        m_done++; m_val = m_buf; m_act = 1'b0;
      end
    end
  endtask

  task automatic idle(input int t);
    repeat (t * TPER) @(negedge clk);
  endtask

  task automatic hold(input logic [15:0] pat, input int t);
    @(negedge clk) keys = pat;
    idle(t);
    keys = '0;
  endtask

  task automatic tap(input int k);
    hold(16'(1) << k, LONG);
    idle(LONG);
    model_key(k);
  endtask

  task automatic begin_entry(input int n);
    @(negedge clk) begin start = 1'b1; len = LW'(n); end
    @(negedge clk) start = 1'b0;
    m_act = 1'b1; m_len = (n > MAXD) ? MAXD : n; m_cnt = 0;
    m_buf = '0; m_disp = '0; m_blank = '1;
  endtask

  task automatic chk_disp(input string tag);
    chk(disp == m_disp && blank == m_blank, tag, {44'(disp), 4'(blank)}, {44'(m_disp), 4'(m_blank)});
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R6
    chk(blank == '1 && value == '0 && !done, "R6 reset", {blank, value[3:0]}, {4'hf, 4'h0});
    // R1 rotation
    begin
      logic [3:0] r0;
      r0 = row;
      for (int i = 0; i < 4; i++) begin
        chk($onehot(row), "R1 onehot", 64'(row), 64'(r0));
        @(negedge clk);
      end
      chk(row == r0, "R1 period", 64'(row), 64'(r0));
    end
    idle(LONG);
    // R12 choice while idle
    tap(3);
    chk(ch_cnt == 1 && ch_val == 3'd2, "R12 key3->C", 64'(ch_val), 64'd2);
    tap(5);
    chk(ch_cnt == 2 && ch_val == 3'd4, "R12 key5->E", 64'(ch_val), 64'd4);
    // R11 digit/SEND idle -> nothing
    tap(7); tap(11);
    chk(ch_cnt == 2 && done_cnt == 0 && blank == '1, "R11 idle keys", 64'(done_cnt), 64'd0);
    // entry of 6 digits
    begin_entry(6);
    chk_disp("R6 start blank");
    tap(1); chk_disp("R7 first digit");
    tap(2); tap(3);
    tap(13); chk_disp("R5 spare key");
    tap(11); chk(done_cnt == 0, "R11 early SEND", 64'(done_cnt), 64'd0);
    tap(4); tap(5); chk_disp("R7 scroll");
    tap(6); chk_disp("R7 six digits");
    tap(9); chk_disp("R8 extra digit");
    tap(11);
    chk(done_cnt == 1 && done_val == m_val && m_val == 36'h123456, "R10 send", 64'(done_val), 64'(m_val));
    // R2 short press ignored
    begin_entry(3);
    hold(16'(1) << 8, SHRT); idle(LONG);
    chk_disp("R2 short press");
    tap(8); chk_disp("R2 long press");
    // R4 multi-key
    hold((16'(1) << 2) | (16'(1) << 7), 3 * LONG); idle(LONG);
    chk_disp("R4 two keys");
    // R3 rearm after short release
    hold(16'(1) << 4, LONG); model_key(4); idle(SHRT);
    hold(16'(1) << 5, LONG); idle(LONG);
    chk_disp("R3 no rearm");
    // R9 clear
    tap(10); chk_disp("R9 clear");
    chk(blank == '1, "R9 blank", 64'(blank), 64'hf);
    tap(7); tap(0); tap(9); tap(11);
    chk(done_cnt == 2 && done_val == 36'h709, "R9 value after clear", 64'(done_val), 64'h709);
    // length clamp R6
    begin_entry(15);
    for (int i = 0; i < 10; i++) tap(i);
    tap(11);
    chk(done_cnt == 3 && done_val == 36'h012345678, "R6 len clamp", 64'(done_val), 64'h012345678);
    chk_disp("R8 clamp display");
    // random entries
    for (int e = 0; e < 12; e++) begin
      int n;
      n = 1 + int'($urandom_range(MAXD - 1));
      begin_entry(n);
      for (int i = 0; i < n; i++) tap(int'($urandom_range(9)));
      chk_disp("R7 random display");
      tap(11);
      chk(done_cnt == m_done && done_val == m_val, "R10 random value", 64'(done_val), 64'(m_val));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule